// File: doc/BRIEF.md
# Pause Frame Refresh Scheduler

This block decides when a flow-control pause frame has to be sent on an Ethernet transmit path, and which classes that frame covers. It has nine channels. Channels 0 to 7 are the priority classes and channel 8 is the global class. For each channel it takes a request bit, an enable bit and a 16-bit refresh interval. It also takes a one-cycle resend strobe and a busy signal from the transmit datapath. The busy signal is high while a data packet is in flight.

The block keeps one countdown timer per channel, so that a pause frame is sent again before the peer's pause runs out. Priority timers are coupled: when one priority class needs a frame, every other running priority class joins it. Any work that comes up while a data packet is in flight is merged into a single pending frame. When a request is withdrawn, the block sends a frame that carries zero quanta for that class, which lifts the peer's pause.

The frame request leaves the block on a valid/ready interface, together with a class mask and per-class zero-quanta flags. The frame builder consumes it. The rules for back-pressure are these:
- Once `frm_valid_o` rises, it stays high until a cycle in which `frm_ready_i` is also high.
- Mask and flags do not change while the frame waits.
- The next frame is not offered until the cycle after an accept.

Work that arrives while a frame is held back is kept for the next frame.

Top module: `pause_sched`

## Requirements
- R1: A channel is active only while both its request bit and its enable bit are 1. Bit n of every per-channel bus and of `frm_mask_o`/`frm_zero_o` is channel n. Bit 8 is global and bits 7..0 are priorities.
- R2: A channel that becomes active produces a frame whose mask bit n is 1 and whose zero bit n is 0.
- R3: On the accept of a frame carrying quanta for a channel, that channel's timer loads its refresh value. If the channel is still active, a further frame for it follows once the timer has counted down to zero, about refresh+3 cycles after the accept.
- R4: A priority frame that carries quanta for any class also carries quanta for every other priority class that is active, has already been paused, and is not waiting in the current frame. This applies to both new requests and timer expiries.
- R5: No frame is offered while `pkt_busy_i` is 1. Requests that arrive while the line is busy go out in one frame when it drops.
- R6: A one-cycle pulse on `resend_i` forces every timer to zero. A frame then follows that covers every active channel that has already been paused.
- R7: When a paused channel stops being active, whether through its request or its enable bit, a frame is sent with both its mask bit and its zero bit set to 1.
- R8: A frame never mixes global and priority classes. While the global channel is active, the priority channels count as inactive, so any paused priority classes receive a zero-quanta frame. Pending global work goes out before pending priority work.
- R9: Whenever the global channel and any priority channel are active together, `mix_err_o` is set to 1 in the next cycle. It stays 1 until reset.
- R10: `frm_valid_o` holds until accepted, and `frm_mask_o`/`frm_zero_o` stay stable while it waits. A zero bit is set only where the mask bit is set.
- R11: After reset `frm_valid_o` and `mix_err_o` are 0, and all timers and pending work are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pause_req_i | input | 9 | Per-channel pause request |
| pause_en_i | input | 9 | Per-channel enable |
| refresh_i | input | 144 | Refresh interval per channel, 16 bits each, channel n at bits 16n+15..16n |
| resend_i | input | 1 | One-cycle strobe that forces all timers to zero |
| pkt_busy_i | input | 1 | A data packet is in flight |
| frm_valid_o | output | 1 | Frame request offered |
| frm_ready_i | input | 1 | Frame builder accepts the offer |
| frm_mask_o | output | 9 | Classes carried in the frame |
| frm_zero_o | output | 9 | Class sends zero quanta (1) or its configured quanta (0) |
| mix_err_o | output | 1 | Sticky flag: global and priority requested together |

## Verification
The scheduling function is tried with several input patterns, each checked against a queue of expected frames:
- A single request and then a second request on top of it. This separates plain launch from request coupling.
- A short refresh interval next to a long one. Here the gap between frames shows the timer reload and the expiry coupling.
- A burst of requests while the line is busy. This shows whether work is merged or sent as separate frames.
- The resend strobe, with no change on any request.
- Withdrawal through the request bit and through the enable bit. Both must give zero-quanta frames.
- Overlapping global and priority requests. These test the frame ordering and the error flag.
- A stalled ready line. This checks that the offered frame stays unchanged.

// File: rtl/pause_pkg.sv
package pause_pkg;
  typedef enum logic {
    CLS_PRIO   = 1'b0,
    CLS_GLOBAL = 1'b1
  } frame_cls_e;
endpackage

// File: rtl/pause_chan_timer.sv
module pause_chan_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eff_i,
  input  logic [TW-1:0] refresh_i,
  input  logic          resend_i,
  input  logic          take_on_i,
  input  logic          take_off_i,
  input  logic          accept_i,
  output logic          pend_on_o,
  output logic          pend_off_o,
  output logic          running_o
);
  logic          eff_q, covered_q, hold_q, pend_on_q, pend_off_q;
  logic [TW-1:0] tmr_q;
  logic          rise, fall, idle_run, expire;

  assign rise     = eff_i & ~eff_q;
  assign fall     = ~eff_i & eff_q;
  assign idle_run = covered_q & eff_i & ~hold_q;
  assign expire   = idle_run & (tmr_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_q      <= 1'b0;
      covered_q  <= 1'b0;
      hold_q     <= 1'b0;
      pend_on_q  <= 1'b0;
      pend_off_q <= 1'b0;
      tmr_q      <= '0;
    end else begin
      eff_q <= eff_i;
      // timer: forced zero, reload on accept, or count down
      if (resend_i)
        tmr_q <= '0;
      else if (accept_i && hold_q)
        tmr_q <= refresh_i;
      else if (idle_run && (tmr_q != '0))
        tmr_q <= tmr_q - 1'b1;
      if (accept_i) hold_q <= 1'b0;
      // quanta work
      if (take_on_i) begin
        pend_on_q <= 1'b0;
        covered_q <= 1'b1;
        hold_q    <= 1'b1;
      end else if (expire) begin
        pend_on_q <= 1'b1;
      end
      if (rise) pend_on_q <= 1'b1;
      // cancel work
      if (take_off_i) pend_off_q <= 1'b0;
      if (fall) begin
        pend_on_q <= 1'b0;
        if (covered_q) begin
          pend_off_q <= 1'b1;
          covered_q  <= 1'b0;
        end
      end
    end
  end

  assign pend_on_o  = pend_on_q & eff_i;
  assign pend_off_o = pend_off_q;
  assign running_o  = idle_run;

  AST_TAKE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    take_on_i |-> eff_i);  // R2
  AST_DROP_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && covered_q && !take_off_i) |=> pend_off_o);  // R7
endmodule

// File: rtl/pause_frame_sel.sv
module pause_frame_sel
  import pause_pkg::*;
#(
  parameter int NPRIO = 8
) (
  input  logic [NPRIO:0] on_i,
  input  logic [NPRIO:0] off_i,
  input  logic [NPRIO:0] run_i,
  output logic [NPRIO:0] sel_on_o,
  output logic [NPRIO:0] sel_off_o,
  output frame_cls_e     cls_o,
  output logic           any_o
);
  localparam int GIDX = NPRIO;
  logic [NPRIO-1:0] p_on;

  always_comb begin
    sel_on_o  = '0;
    sel_off_o = '0;
    p_on      = on_i[NPRIO-1:0];
    if (on_i[GIDX] || off_i[GIDX]) begin
      cls_o           = CLS_GLOBAL;
      sel_on_o[GIDX]  = on_i[GIDX];
      sel_off_o[GIDX] = off_i[GIDX];
    end else begin
      cls_o = CLS_PRIO;
      if (|p_on) p_on = p_on | run_i[NPRIO-1:0];
      sel_on_o[NPRIO-1:0]  = p_on;
      sel_off_o[NPRIO-1:0] = off_i[NPRIO-1:0];
    end
    any_o = |(sel_on_o | sel_off_o);
  end
endmodule

// File: rtl/pause_sched.sv
module pause_sched
  import pause_pkg::*;
#(
  parameter int NPRIO = 8,
  parameter int TW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPRIO:0]           pause_req_i,
  input  logic [NPRIO:0]           pause_en_i,
  input  logic [(NPRIO+1)*TW-1:0]  refresh_i,
  input  logic                     resend_i,
  input  logic                     pkt_busy_i,
  output logic                     frm_valid_o,
  input  logic                     frm_ready_i,
  output logic [NPRIO:0]           frm_mask_o,
  output logic [NPRIO:0]           frm_zero_o,
  output logic                     mix_err_o
);
  localparam int CH   = NPRIO + 1;
  localparam int GIDX = NPRIO;

  logic [CH-1:0] act, eff, on, off, run, sel_on, sel_off;
  logic          any, launch, accept, err_q, valid_q;
  logic [CH-1:0] mask_q, zero_q;
  frame_cls_e    cls, cls_q;

  assign act = pause_req_i & pause_en_i;
  // global wins: priorities count as inactive while global is active
  assign eff = {act[GIDX], act[NPRIO-1:0] & {NPRIO{~act[GIDX]}}};

  assign accept = valid_q & frm_ready_i;
  assign launch = ~valid_q & ~pkt_busy_i & any;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    pause_chan_timer #(.TW(TW)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .eff_i      (eff[c]),
      .refresh_i  (refresh_i[c*TW +: TW]),
      .resend_i   (resend_i),
      .take_on_i  (launch & sel_on[c]),
      .take_off_i (launch & sel_off[c]),
      .accept_i   (accept),
      .pend_on_o  (on[c]),
      .pend_off_o (off[c]),
      .running_o  (run[c])
    );
  end

  pause_frame_sel #(.NPRIO(NPRIO)) u_sel (
    .on_i      (on),
    .off_i     (off),
    .run_i     (run),
    .sel_on_o  (sel_on),
    .sel_off_o (sel_off),
    .cls_o     (cls),
    .any_o     (any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
      zero_q  <= '0;
      cls_q   <= CLS_PRIO;
      err_q   <= 1'b0;
    end else begin
      if (launch) begin
        valid_q <= 1'b1;
        mask_q  <= sel_on | sel_off;
        zero_q  <= sel_off;
        cls_q   <= cls;
      end else if (accept) begin
        valid_q <= 1'b0;
      end
      if (act[GIDX] && (|act[NPRIO-1:0])) err_q <= 1'b1;
    end
  end

  assign frm_valid_o = valid_q;
  assign frm_mask_o  = mask_q;
  assign frm_zero_o  = zero_q;
  assign mix_err_o   = err_q;

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid_o && !frm_ready_i) |=> (frm_valid_o && $stable(frm_mask_o) && $stable(frm_zero_o)));  // R10
  AST_ZERO_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid_o |-> (((frm_zero_o & ~frm_mask_o) == '0) && (frm_mask_o != '0)));  // R10
  AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid_o |-> !(frm_mask_o[GIDX] && (|frm_mask_o[NPRIO-1:0])));  // R8
  AST_CLASS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid_o |-> ((cls_q == CLS_GLOBAL) == frm_mask_o[GIDX]));  // R8
  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_valid_o && pkt_busy_i) |=> !frm_valid_o);  // R5
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (act[GIDX] && (|act[NPRIO-1:0])) |=> mix_err_o);  // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mix_err_o |=> mix_err_o);  // R9
endmodule

// File: tb/tb_pause_sched.sv
module tb_pause_sched;
  localparam int NPRIO = 8;
  localparam int CH    = NPRIO + 1;
  localparam int TW    = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [CH-1:0]     req, en;
  logic [CH*TW-1:0]  refresh;
  logic              resend, busy, valid, ready, err;
  logic [CH-1:0]     mask, zero;

  int checks = 0, errors = 0, seen = 0, cyc = 0;
  int acc_cyc[$];
  logic [2*CH-1:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pause_sched #(.NPRIO(NPRIO), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .pause_req_i(req), .pause_en_i(en),
    .refresh_i(refresh), .resend_i(resend), .pkt_busy_i(busy),
    .frm_valid_o(valid), .frm_ready_i(ready), .frm_mask_o(mask),
    .frm_zero_o(zero), .mix_err_o(err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act_v, exp_v);
    end
  endtask

  task automatic expect_frame(input logic [CH-1:0] m, input logic [CH-1:0] z, input string tag);
    exp_q.push_back({m, z});
    tag_q.push_back(tag);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_frames(input int target, input string tag);
    int t = 0;
    while (seen < target && t < 2000) begin
      @(posedge clk);
      t++;
    end
    #1;
    check(seen >= target, tag, seen, target);
  endtask

  // monitor: pop expected frame on each accept
  always @(negedge clk) begin
    if (rst_n && valid && ready) begin
      seen++;
      acc_cyc.push_back(cyc);
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected frame", {mask, zero}, 0);
      end else begin
        logic [2*CH-1:0] e;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        check({mask, zero} == e, tg, {mask, zero}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = '0; en = '1; resend = 1'b0; busy = 1'b0; ready = 1'b1;
    for (int c = 0; c < CH; c++) refresh[c*TW +: TW] = 16'd3000;
    refresh[5*TW +: TW] = 16'd50;
    tick(4);
    rst_n = 1'b1;
    tick(3);
    @(negedge clk);
    check(valid == 1'b0, "R11 valid after reset", valid, 0);
    check(err == 1'b0, "R11 err after reset", err, 0);

    // R2: single priority request
    expect_frame(9'h008, 9'h000, "R2 first request");
    @(posedge clk); #1 req[3] = 1'b1;
    wait_frames(1, "R2 frame seen");

    // R4: new request couples running class 3
    expect_frame(9'h028, 9'h000, "R4 request coupling");
    tick(5); req[5] = 1'b1;
    wait_frames(2, "R4 frame seen");

    // R3 + R4: class 5 expiry pulls class 3 along
    expect_frame(9'h028, 9'h000, "R3 R4 expiry coupling");
    wait_frames(3, "R3 expiry frame seen");
    check((acc_cyc[2] - acc_cyc[1]) >= 51 && (acc_cyc[2] - acc_cyc[1]) <= 56,
          "R3 refresh gap", acc_cyc[2] - acc_cyc[1], 53);

    // R7: withdraw class 5 by its request bit
    expect_frame(9'h020, 9'h020, "R7 cancel by request");
    req[5] = 1'b0;
    wait_frames(4, "R7 frame seen");

    // R5: requests under busy merge into one frame
    tick(5); busy = 1'b1;
    tick(2); req[0] = 1'b1;
    tick(7); req[1] = 1'b1;
    tick(20);
    @(negedge clk);
    check(valid == 1'b0, "R5 no offer while busy", valid, 0);
    expect_frame(9'h00B, 9'h000, "R5 merged frame");
    @(posedge clk); #1 busy = 1'b0;
    wait_frames(5, "R5 frame seen");

    // R6: resend strobe
    expect_frame(9'h00B, 9'h000, "R6 resend");
    tick(10); resend = 1'b1;
    tick(1); resend = 1'b0;
    wait_frames(6, "R6 frame seen");

    // R10: back-pressure keeps the offer stable
    tick(5); ready = 1'b0; req[7] = 1'b1;
    tick(6);
    @(negedge clk);
    check(valid == 1'b1 && mask == 9'h08B, "R10 offer under stall", {valid, mask}, {1'b1, 9'h08B});
    tick(4);
    @(negedge clk);
    check(valid == 1'b1 && mask == 9'h08B && zero == 9'h000, "R10 offer stable", {valid, mask}, {1'b1, 9'h08B});
    expect_frame(9'h08B, 9'h000, "R4 R10 stalled frame");
    @(posedge clk); #1 ready = 1'b1;
    wait_frames(7, "R10 frame seen");

    // R8 R9: global overrides priorities
    expect_frame(9'h100, 9'h000, "R8 global first");
    expect_frame(9'h08B, 9'h08B, "R8 priority cancel");
    tick(5); req[8] = 1'b1;
    wait_frames(9, "R8 frames seen");
    @(negedge clk);
    check(err == 1'b1, "R9 error set", err, 1);

    // R8: global drop, priorities resume
    expect_frame(9'h100, 9'h100, "R8 global cancel");
    expect_frame(9'h08B, 9'h000, "R8 priority resume");
    @(posedge clk); #1 req[8] = 1'b0;
    wait_frames(11, "R8 resume seen");
    @(negedge clk);
    check(err == 1'b1, "R9 error sticky", err, 1);

    // R1: enable gating withdraws class 7
    expect_frame(9'h080, 9'h080, "R1 enable gating");
    tick(5); en[7] = 1'b0;
    wait_frames(12, "R1 frame seen");

    // R7: drop all
    expect_frame(9'h00B, 9'h00B, "R7 drop all");
    tick(5); req = '0;
    wait_frames(13, "R7 final frame seen");
    tick(30);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    check(seen == 13, "frame count", seen, 13);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule